// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the host-facing register front end of an eight-line interrupt controller. A host talks to it through a byte-wide port with a one-bit address, a write strobe and a read strobe. Writes to the low address carry either a start-of-setup word or an operation command. Writes to the high address carry setup data while a setup is in progress, and load the line mask once it has finished. The block runs the setup through a short sequence of stages. The flags captured in the first word decide which stages are visited.

Toward the priority core, the block holds the mask, the vector base and the mode bits as registered levels. It reports each command as a registered code that lasts one cycle, together with a line number. From the core it receives the request and in-service vectors and the current grant, and uses them to serve reads and the poll protocol. All read data is registered and appears in the cycle after the read strobe.

Top module: `intc_prog_seq`

## Requirements
- R1: A write to address 0 with bit 4 set starts a setup. In the next cycle cmd_kind is 1 (setup), and mask_bits, vec_base, nested_mode, auto_ack, rot_on_auto and spec_mask are 0. Read-select returns to the request vector and any pending poll is dropped. Bit 0 is captured as "mode word follows", bit 1 as "single unit", and the sequencer enters the base stage.
- R2: In the base stage, an address-1 write stores wdata with bits 2:0 forced to 0 as vec_base. The next stage is the mode stage if "single unit" and "mode word follows" are both set. It is idle if only "single unit" is set, and the cascade stage in every other case.
- R3: In the cascade stage, an address-1 write leaves mask_bits and every mode output unchanged. The sequencer then goes to the mode stage if "mode word follows" is set, and to idle otherwise.
- R4: In the mode stage, an address-1 write sets nested_mode from bit 4 and auto_ack from bit 1, then returns to idle.
- R5: In the idle stage, an address-1 write loads mask_bits with wdata in the next cycle. Without a write, mask_bits, vec_base, nested_mode and auto_ack never change.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word, and it issues no command code.
  - Bit 2 arms a poll.
  - When bit 1 is set, the read-select takes bit 0 (1 selects the in-service vector).
  - When bit 6 is set, spec_mask takes bit 5.
- R7: An address-0 write with bits 4 and 3 clear is decoded on bits 7:5, with cmd_line taking bits 2:0:
  - Codes 0 and 4 load rot_on_auto from bit 7 and issue no command.
  - Code 1 issues cmd_kind 2 (plain end-of-service).
  - Code 5 issues cmd_kind 3 (rotating end-of-service).
  - Code 3 issues cmd_kind 4 (end-of-service for the named line).
  - Code 6 issues cmd_kind 5 (set lowest priority).
  - Code 7 issues cmd_kind 6 (rotating end-of-service for the named line).
  - Code 2 has no effect.
  - A command code is non-zero for exactly one cycle and then returns to 0, unless another command follows at once.
- R8: A read while a poll is armed ignores the address and disarms the poll.
  - If grant_vld is high, rdata becomes 0x80 OR grant_line, and cmd_kind 7 (poll acknowledge) is issued with cmd_line equal to grant_line.
  - If grant_vld is low, rdata becomes 0 and no command is issued.
- R9: A read without an armed poll returns svc_bits (read-select 1) or req_bits (read-select 0) at address 0, and mask_bits at address 1. rdata updates in the cycle after the read strobe and holds its value in every cycle that has no read.
- R10: When wr_en and rd_en are high in the same cycle, the write is performed and the read is ignored. rdata holds its value and an armed poll stays armed.
- R11: After reset, rdata, mask_bits, vec_base, cmd_kind, cmd_line and all mode outputs are 0, and the read-select is the request vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered read data |
| req_bits | input | 8 | Request vector from the core |
| svc_bits | input | 8 | In-service vector from the core |
| grant_vld | input | 1 | Core has a line to grant |
| grant_line | input | 3 | Line the core would grant |
| mask_bits | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| nested_mode | output | 1 | Special nested mode enable |
| auto_ack | output | 1 | Automatic end-of-service enable |
| rot_on_auto | output | 1 | Rotate on automatic end-of-service |
| spec_mask | output | 1 | Special mask mode |
| cmd_kind | output | 3 | One-cycle command code, 0 when idle |
| cmd_line | output | 3 | Line argument of the command |

## Verification
Each path through the setup sequence is walked, because errors there show up as misplaced data:
- A sequencer that picks the wrong next stage treats the next data byte as the mask or as the mode word.
- One that does not discard the cascade byte corrupts the mask.

Every operation code is driven. A decoder that confuses codes 2, 4 or 0 with commands would emit stray pulses or disturb the rotate flag.

The enable bits of the control word are exercised with their enable bit clear, to catch a design that loads read-select or special mask unconditionally. The poll is exercised with and without a grant, and when a write coincides with the read. A faulty design here would return stale register data instead of the poll byte, fail to disarm, or lose the poll to a simultaneous write.

// File: rtl/intc_seq_pkg.sv
package intc_seq_pkg;
  localparam int DW    = 8;
  localparam int LINES = 8;
  localparam int LW    = $clog2(LINES);
  localparam int CKW   = 3;

  // word classification bits on address 0
  localparam int BIT_SETUP = 4;
  localparam int BIT_CTRL  = 3;
  // setup word flags
  localparam int BIT_MODEW = 0;
  localparam int BIT_SINGLE = 1;
  // mode word fields
  localparam int BIT_NEST  = 4;
  localparam int BIT_AUTO  = 1;
  // control word fields
  localparam int BIT_POLL  = 2;
  localparam int BIT_RSEN  = 1;
  localparam int BIT_RSV   = 0;
  localparam int BIT_SMEN  = 6;
  localparam int BIT_SMV   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [CKW-1:0] {
    CK_NONE      = 3'd0,
    CK_SETUP     = 3'd1,
    CK_EOI       = 3'd2,
    CK_EOI_ROT   = 3'd3,
    CK_EOI_LINE  = 3'd4,
    CK_SET_PRIO  = 3'd5,
    CK_EOI_LROT  = 3'd6,
    CK_POLL_ACK  = 3'd7
  } cmd_kind_e;
endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_bits,
  output logic [DW-1:0] vec_base,
  output logic          nested_mode,
  output logic          auto_ack
);
  init_st_e      st_q, st_d;
  logic          modew_q, modew_d;
  logic          single_q, single_d;
  logic [DW-1:0] mask_q, mask_d;
  logic [DW-1:0] base_q, base_d;
  logic          nest_q, nest_d;
  logic          auto_q, auto_d;
  logic          upd_en;

  assign upd_en = setup_wr | data_wr;

  always_comb begin
    st_d     = st_q;
    modew_d  = modew_q;
    single_d = single_q;
    mask_d   = mask_q;
    base_d   = base_q;
    nest_d   = nest_q;
    auto_d   = auto_q;
    if (setup_wr) begin
      st_d     = ST_BASE;
      modew_d  = wdata[BIT_MODEW];
      single_d = wdata[BIT_SINGLE];
      mask_d   = '0;
      base_d   = '0;
      nest_d   = 1'b0;
      auto_d   = 1'b0;
    end else if (data_wr) begin
      unique case (st_q)
        ST_IDLE: mask_d = wdata;
        ST_BASE: begin
          base_d = {wdata[DW-1:LW], {LW{1'b0}}};
          if (single_q) st_d = modew_q ? ST_MODE : ST_IDLE;
          else          st_d = ST_CASC;
        end
        ST_CASC: st_d = modew_q ? ST_MODE : ST_IDLE;
        ST_MODE: begin
          nest_d = wdata[BIT_NEST];
          auto_d = wdata[BIT_AUTO];
          st_d   = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      modew_q  <= 1'b0;
      single_q <= 1'b0;
      mask_q   <= '0;
      base_q   <= '0;
      nest_q   <= 1'b0;
      auto_q   <= 1'b0;
    end else if (upd_en) begin
      st_q     <= st_d;
      modew_q  <= modew_d;
      single_q <= single_d;
      mask_q   <= mask_d;
      base_q   <= base_d;
      nest_q   <= nest_d;
      auto_q   <= auto_d;
    end
  end

  assign mask_bits   = mask_q;
  assign vec_base    = base_q;
  assign nested_mode = nest_q;
  assign auto_ack    = auto_q;
endmodule

// File: rtl/intc_cmd_dec.sv
module intc_cmd_dec
  import intc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           setup_wr,
  input  logic           op_wr,
  input  logic           read_fire,
  input  logic [DW-1:0]  wdata,
  input  logic           ack_req,
  input  logic [LW-1:0]  ack_line,
  output logic           poll_pend,
  output logic           rd_sel,
  output logic           spec_mask,
  output logic           rot_on_auto,
  output logic [CKW-1:0] cmd_kind,
  output logic [LW-1:0]  cmd_line
);
  logic      poll_q, poll_d;
  logic      rsel_q, rsel_d;
  logic      smask_q, smask_d;
  logic      rot_q, rot_d;
  cmd_kind_e ck_q, ck_d;
  logic [LW-1:0] ln_q, ln_d;
  logic      ctrl_wr, code_wr, mode_en;

  assign ctrl_wr = op_wr &  wdata[BIT_CTRL];
  assign code_wr = op_wr & ~wdata[BIT_CTRL];
  assign mode_en = setup_wr | op_wr | read_fire;

  always_comb begin
    poll_d  = poll_q;
    rsel_d  = rsel_q;
    smask_d = smask_q;
    rot_d   = rot_q;
    ck_d    = CK_NONE;
    ln_d    = '0;
    if (setup_wr) begin
      poll_d  = 1'b0;
      rsel_d  = 1'b0;
      smask_d = 1'b0;
      rot_d   = 1'b0;
      ck_d    = CK_SETUP;
    end else if (ctrl_wr) begin
      if (wdata[BIT_POLL]) poll_d  = 1'b1;
      if (wdata[BIT_RSEN]) rsel_d  = wdata[BIT_RSV];
      if (wdata[BIT_SMEN]) smask_d = wdata[BIT_SMV];
    end else if (code_wr) begin
      ln_d = wdata[LW-1:0];
      unique case (wdata[DW-1:DW-3])
        3'd0, 3'd4: rot_d = wdata[DW-1];
        3'd1:       ck_d  = CK_EOI;
        3'd5:       ck_d  = CK_EOI_ROT;
        3'd3:       ck_d  = CK_EOI_LINE;
        3'd6:       ck_d  = CK_SET_PRIO;
        3'd7:       ck_d  = CK_EOI_LROT;
        default:    ck_d  = CK_NONE;
      endcase
    end else if (read_fire) begin
      poll_d = 1'b0;
      if (ack_req) begin
        ck_d = CK_POLL_ACK;
        ln_d = ack_line;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q  <= 1'b0;
      rsel_q  <= 1'b0;
      smask_q <= 1'b0;
      rot_q   <= 1'b0;
    end else if (mode_en) begin
      poll_q  <= poll_d;
      rsel_q  <= rsel_d;
      smask_q <= smask_d;
      rot_q   <= rot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= CK_NONE;
      ln_q <= '0;
    end else begin
      ck_q <= ck_d;
      ln_q <= ln_d;
    end
  end

  assign poll_pend   = poll_q;
  assign rd_sel      = rsel_q;
  assign spec_mask   = smask_q;
  assign rot_on_auto = rot_q;
  assign cmd_kind    = ck_q;
  assign cmd_line    = ln_q;
endmodule

// File: rtl/intc_rd_port.sv
module intc_rd_port
  import intc_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          read_fire,
  input  logic          addr,
  input  logic          poll_pend,
  input  logic          rd_sel,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] svc_bits,
  input  logic [DW-1:0] mask_bits,
  input  logic          grant_vld,
  input  logic [LW-1:0] grant_line,
  output logic          ack_req,
  output logic [LW-1:0] ack_line,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_q, rd_d, poll_byte;

  always_comb begin
    poll_byte = '0;
    if (grant_vld) begin
      poll_byte[DW-1]   = 1'b1;
      poll_byte[LW-1:0] = grant_line;
    end
  end

  always_comb begin
    if (poll_pend)     rd_d = poll_byte;
    else if (addr)     rd_d = mask_bits;
    else if (rd_sel)   rd_d = svc_bits;
    else               rd_d = req_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_q <= '0;
    else if (read_fire) rd_q <= rd_d;
  end

  assign ack_req  = read_fire & poll_pend & grant_vld;
  assign ack_line = grant_line;
  assign rdata    = rd_q;
endmodule

// File: rtl/intc_prog_seq.sv
module intc_prog_seq
  import intc_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic           addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  input  logic [DW-1:0]  req_bits,
  input  logic [DW-1:0]  svc_bits,
  input  logic           grant_vld,
  input  logic [LW-1:0]  grant_line,
  output logic [DW-1:0]  mask_bits,
  output logic [DW-1:0]  vec_base,
  output logic           nested_mode,
  output logic           auto_ack,
  output logic           rot_on_auto,
  output logic           spec_mask,
  output logic [CKW-1:0] cmd_kind,
  output logic [LW-1:0]  cmd_line
);
  logic setup_wr, op_wr, data_wr, read_fire;
  logic poll_pend, rd_sel, ack_req;
  logic [LW-1:0] ack_line;

  assign setup_wr  = wr_en & ~addr &  wdata[BIT_SETUP];
  assign op_wr     = wr_en & ~addr & ~wdata[BIT_SETUP];
  assign data_wr   = wr_en &  addr;
  assign read_fire = rd_en & ~wr_en;

  intc_init_seq u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_wr   (setup_wr),
    .data_wr    (data_wr),
    .wdata      (wdata),
    .mask_bits  (mask_bits),
    .vec_base   (vec_base),
    .nested_mode(nested_mode),
    .auto_ack   (auto_ack)
  );

  intc_cmd_dec u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_wr   (setup_wr),
    .op_wr      (op_wr),
    .read_fire  (read_fire),
    .wdata      (wdata),
    .ack_req    (ack_req),
    .ack_line   (ack_line),
    .poll_pend  (poll_pend),
    .rd_sel     (rd_sel),
    .spec_mask  (spec_mask),
    .rot_on_auto(rot_on_auto),
    .cmd_kind   (cmd_kind),
    .cmd_line   (cmd_line)
  );

  intc_rd_port u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .read_fire (read_fire),
    .addr      (addr),
    .poll_pend (poll_pend),
    .rd_sel    (rd_sel),
    .req_bits  (req_bits),
    .svc_bits  (svc_bits),
    .mask_bits (mask_bits),
    .grant_vld (grant_vld),
    .grant_line(grant_line),
    .ack_req   (ack_req),
    .ack_line  (ack_line),
    .rdata     (rdata)
  );
endmodule

// File: rtl/intc_prog_seq_chk.sv
module intc_prog_seq_chk
  import intc_seq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic           rd_en,
  input logic           addr,
  input logic [DW-1:0]  wdata,
  input logic [DW-1:0]  rdata,
  input logic [DW-1:0]  mask_bits,
  input logic [DW-1:0]  vec_base,
  input logic           nested_mode,
  input logic           auto_ack,
  input logic           rot_on_auto,
  input logic           spec_mask,
  input logic [CKW-1:0] cmd_kind
);
  // R1
  setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[BIT_SETUP]) |=>
      (cmd_kind == CK_SETUP && mask_bits == '0 && vec_base == '0 &&
       !nested_mode && !auto_ack && !rot_on_auto && !spec_mask));

  // R5
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_bits) && $stable(vec_base) &&
                $stable(nested_mode) && $stable(auto_ack)));

  // R7
  code2_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && !wdata[BIT_SETUP] && !wdata[BIT_CTRL] &&
     wdata[DW-1:DW-3] == 3'd2) |=> (cmd_kind == CK_NONE && $stable(rot_on_auto)));

  // R7
  cmd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> (cmd_kind == CK_NONE));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> ($stable(rdata) && cmd_kind != CK_POLL_ACK));
endmodule

bind intc_prog_seq intc_prog_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .mask_bits  (mask_bits),
  .vec_base   (vec_base),
  .nested_mode(nested_mode),
  .auto_ack   (auto_ack),
  .rot_on_auto(rot_on_auto),
  .spec_mask  (spec_mask),
  .cmd_kind   (cmd_kind)
);

// File: tb/tb_intc_prog_seq.sv
`timescale 1ns/1ps
module tb_intc_prog_seq;
  logic       clk, rst_n, wr_en, rd_en, addr, grant_vld;
  logic [7:0] wdata, rdata, req_bits, svc_bits, mask_bits, vec_base;
  logic [2:0] grant_line, cmd_kind, cmd_line;
  logic       nested_mode, auto_ack, rot_on_auto, spec_mask;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  intc_prog_seq dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr_rd(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 rdata", rdata, 0);
    chk("R11 mask", mask_bits, 0);
    chk("R11 base", vec_base, 0);
    chk("R11 modes", {nested_mode, auto_ack, rot_on_auto, spec_mask}, 0);
    chk("R11 cmd", {cmd_kind, cmd_line}, 0);
    rd(1'b0);
    chk("R11 read-select is request", rdata, 8'h5A);
  endtask

  task automatic t_setup_full;
    wr(1'b0, 8'h11);
    chk("R1 setup pulse", cmd_kind, 1);
    @(negedge clk);
    chk("R1 pulse one cycle", cmd_kind, 0);
    wr(1'b1, 8'h4D);
    chk("R2 base masked", vec_base, 8'h48);
    wr(1'b1, 8'hFF);
    chk("R3 cascade byte dropped", mask_bits, 0);
    chk("R3 cascade no mode", {nested_mode, auto_ack}, 0);
    wr(1'b1, 8'h12);
    chk("R4 mode word", {nested_mode, auto_ack}, 2'b11);
    chk("R4 mask untouched", mask_bits, 0);
    wr(1'b1, 8'hA5);
    chk("R5 mask load", mask_bits, 8'hA5);
  endtask

  task automatic t_setup_paths;
    wr(1'b0, 8'h13);
    chk("R1 mask cleared", mask_bits, 0);
    chk("R1 modes cleared", {nested_mode, auto_ack}, 0);
    wr(1'b1, 8'h20);
    chk("R2 single base", vec_base, 8'h20);
    wr(1'b1, 8'h02);
    chk("R2 single to mode stage", {nested_mode, auto_ack}, 2'b01);
    wr(1'b1, 8'h0F);
    chk("R5 mask after single", mask_bits, 8'h0F);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h08);
    chk("R2 base 08", vec_base, 8'h08);
    wr(1'b1, 8'h77);
    chk("R2 single no mode word goes idle", mask_bits, 8'h77);
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h30);
    wr(1'b1, 8'h55);
    chk("R3 cascade to idle drops byte", mask_bits, 0);
    wr(1'b1, 8'h66);
    chk("R3 then idle mask", mask_bits, 8'h66);
    chk("R3 no mode word", {nested_mode, auto_ack}, 0);
  endtask

  task automatic t_codes;
    logic [2:0] codes [5] = '{3'd1, 3'd5, 3'd3, 3'd6, 3'd7};
    int kinds [5] = '{2, 3, 4, 5, 6};
    for (int i = 0; i < 5; i++) begin
      wr(1'b0, {codes[i], 2'b00, 3'(i + 2)});
      chk("R7 code kind", cmd_kind, kinds[i]);
      chk("R7 code line", cmd_line, i + 2);
      @(negedge clk);
      chk("R7 one-cycle pulse", cmd_kind, 0);
    end
    wr(1'b0, 8'h80);
    chk("R7 code4 no pulse", cmd_kind, 0);
    chk("R7 code4 rot set", rot_on_auto, 1);
    wr(1'b0, 8'h47);
    chk("R7 code2 no pulse", cmd_kind, 0);
    chk("R7 code2 rot kept", rot_on_auto, 1);
    wr(1'b0, 8'h00);
    chk("R7 code0 rot clear", rot_on_auto, 0);
    chk("R7 code0 no pulse", cmd_kind, 0);
  endtask

  task automatic t_ctrl;
    rd(1'b0);
    chk("R9 request read", rdata, 8'h5A);
    wr(1'b0, 8'h0B);
    chk("R6 ctrl no pulse", cmd_kind, 0);
    rd(1'b0);
    chk("R6 select in-service", rdata, 8'hC3);
    wr(1'b0, 8'h08);
    rd(1'b0);
    chk("R6 select kept without enable", rdata, 8'hC3);
    wr(1'b0, 8'h0A);
    rd(1'b0);
    chk("R6 select request", rdata, 8'h5A);
    wr(1'b0, 8'h68);
    chk("R6 special mask set", spec_mask, 1);
    wr(1'b0, 8'h28);
    chk("R6 special mask kept", spec_mask, 1);
    wr(1'b0, 8'h48);
    chk("R6 special mask clear", spec_mask, 0);
    rd(1'b1);
    chk("R9 mask read", rdata, mask_bits);
    @(negedge clk); @(negedge clk);
    chk("R9 rdata hold", rdata, mask_bits);
  endtask

  task automatic t_poll;
    grant_vld = 1'b1; grant_line = 3'd5;
    wr(1'b0, 8'h0C);
    rd(1'b1);
    chk("R8 poll byte", rdata, 8'h85);
    chk("R8 poll ack kind", cmd_kind, 7);
    chk("R8 poll ack line", cmd_line, 5);
    rd(1'b1);
    chk("R8 poll disarmed", rdata, 8'h66);
    grant_vld = 1'b0;
    wr(1'b0, 8'h0C);
    rd(1'b0);
    chk("R8 empty poll", rdata, 0);
    chk("R8 empty poll no ack", cmd_kind, 0);
    rd(1'b0);
    chk("R8 empty poll disarmed", rdata, 8'h5A);
  endtask

  task automatic t_collide;
    grant_vld = 1'b1; grant_line = 3'd3;
    rd(1'b1);
    wr(1'b0, 8'h0C);
    wr_rd(1'b1, 8'h11);
    chk("R10 write done", mask_bits, 8'h11);
    chk("R10 read ignored", rdata, 8'h66);
    chk("R10 no ack", cmd_kind, 0);
    rd(1'b0);
    chk("R10 poll still armed", rdata, 8'h83);
    wr(1'b0, 8'h0E);
    wr(1'b0, 8'h0C);
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h00);
    rd(1'b0);
    chk("R1 setup drops poll and select", rdata, 8'h5A);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 1'b0; wdata = '0;
    req_bits = 8'h5A; svc_bits = 8'hC3; grant_vld = 1'b0; grant_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_full();
    t_setup_paths();
    t_codes();
    t_ctrl();
    t_poll();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule